// File: doc/BRIEF.md
# Branch and Delay-Slot Controller

This block sits beside the decode stage of a core that fetches a fixed stream of 16-bit instructions. It watches every accepted instruction and picks out the control-flow forms: PC-relative branches with 12-bit or 8-bit displacements, conditional branches on the T flag, register-relative branches, register jumps, subroutine calls and the two return forms. For each one it works out the next program counter and signals the fetch unit when to redirect.

Most control-flow forms have a delay slot. The next accepted instruction runs first, and the redirect follows it. The two plain conditional branches have no slot and redirect on their own. Some instructions may not appear in a slot: every control-flow form, trap, the PC-relative loads and address computation, and both status-register loads. When the block sees one of these there, it raises a one-cycle fault pulse and drops the pending redirect. Calls return PC+4 on a link-write port so that the core can update its return register.

All outputs are registered. Each takes effect in the cycle after the instruction that causes it is accepted.

Top module: `branch_slot_ctrl`

## Requirements
- R1: After reset, redirect_o, link_we_o and slot_illegal_o are low and target_o and link_addr_o are zero.
- R2: A 12-bit branch (instr[15:12]=0xA) or 12-bit call (instr[15:12]=0xB) targets pc+4+sext(instr[11:0])*2. It always takes effect and has a delay slot.
- R3: The slotless conditional branches are taken when T=1 for high byte 0x89 and when T=0 for high byte 0x8B. They target pc+4+sext(instr[7:0])*2, and a taken one pulses redirect_o in the cycle after the branch itself is accepted.
- R4: The slotted conditional branches are taken when T=1 for high byte 0x8D and when T=0 for high byte 0x8F. Taken or not, the next accepted instruction is treated as a slot. A taken one pulses redirect_o only in the cycle after a legal slot instruction is accepted.
- R5: Register-relative branch 0000nnnn00100011 and call 0000nnnn00000011 target pc+4+reg_val_i and have a delay slot.
- R6: Register jump 0100nnnn00101011 and jump-to-subroutine 0100nnnn00001011 target reg_val_i and have a delay slot.
- R7: Return 0x000B targets ret_addr_i and exception return 0x002B targets exc_pc_i. Each value is sampled when the return is accepted, and both returns have a delay slot.
- R8: Each accepted call (12-bit, register-relative or register jump) pulses link_we_o for one cycle, with link_addr_o = pc+4 of the call.
- R9: In a slot, the following are faults: any control-flow form above, high byte 0xC3 or 0xC7, top nibble 0x9 or 0xD, and 0100mmmm00001110 or 0100mmmm00000111. A fault pulses slot_illegal_o for one cycle, cancels the pending redirect and produces no redirect or link write.
- R10: Cycles with valid_i low change nothing and produce no pulse. A pending slot waits for the next valid instruction.
- R11: An instruction outside a slot that is not a control-flow form produces no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction accepted this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| t_flag_i | input | 1 | Condition flag |
| reg_val_i | input | 32 | Value of register n |
| ret_addr_i | input | 32 | Saved subroutine return address |
| exc_pc_i | input | 32 | Saved exception-return PC |
| redirect_o | output | 1 | Fetch redirect pulse |
| target_o | output | 32 | Redirect target |
| link_we_o | output | 1 | Return-register write pulse |
| link_addr_o | output | 32 | Return address to write |
| slot_illegal_o | output | 1 | Illegal slot instruction pulse |

## Verification
A lost or stuck slot flag shows up in the cycle after the next valid instruction. Depending on which way the flag is wrong, the bench sees a redirect that never comes, a redirect one instruction early, or a spurious fault pulse. A stale pending bit or a stale captured target shows up in the redirect that follows the next slot instruction. The reference model compares all outputs every cycle, including stalled cycles inside a slot. Because of that, any divergence is reported within one instruction of its cause.

// File: rtl/brslot_pkg.sv
package brslot_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_BT, K_BF, K_BTS, K_BFS, K_BRA, K_BSR,
    K_BRAF, K_BSRF, K_JMP, K_JSR, K_RTS, K_RTE
  } br_kind_e;
endpackage

// File: rtl/brslot_decode.sv
module brslot_decode
  import brslot_pkg::*;
(
  input  logic [15:0] instr_i,
  input  logic        t_flag_i,
  output br_kind_e    kind_o,
  output logic        branch_o,
  output logic        delayed_o,
  output logic        taken_o,
  output logic        call_o,
  output logic        illegal_o
);
  logic [3:0] hi4;
  logic [7:0] hi8, lo8;
  logic       other_bad;

  assign hi4 = instr_i[15:12];
  assign hi8 = instr_i[15:8];
  assign lo8 = instr_i[7:0];

  always_comb begin
    kind_o = K_NONE;
    if (hi4 == 4'hA)                          kind_o = K_BRA;
    else if (hi4 == 4'hB)                     kind_o = K_BSR;
    else if (hi8 == 8'h89)                    kind_o = K_BT;
    else if (hi8 == 8'h8B)                    kind_o = K_BF;
    else if (hi8 == 8'h8D)                    kind_o = K_BTS;
    else if (hi8 == 8'h8F)                    kind_o = K_BFS;
    else if (instr_i == 16'h000B)             kind_o = K_RTS;
    else if (instr_i == 16'h002B)             kind_o = K_RTE;
    else if (hi4 == 4'h0 && lo8 == 8'h23)     kind_o = K_BRAF;
    else if (hi4 == 4'h0 && lo8 == 8'h03)     kind_o = K_BSRF;
    else if (hi4 == 4'h4 && lo8 == 8'h2B)     kind_o = K_JMP;
    else if (hi4 == 4'h4 && lo8 == 8'h0B)     kind_o = K_JSR;
  end

  always_comb begin
    case (kind_o)
      K_BT, K_BTS: taken_o = t_flag_i;
      K_BF, K_BFS: taken_o = ~t_flag_i;
      K_NONE:      taken_o = 1'b0;
      default:     taken_o = 1'b1;
    endcase
  end

  assign branch_o  = (kind_o != K_NONE);
  assign delayed_o = branch_o && kind_o != K_BT && kind_o != K_BF;
  assign call_o    = (kind_o == K_BSR) || (kind_o == K_BSRF) || (kind_o == K_JSR);

  // trap, address-of, pc-relative loads, status register loads
  assign other_bad = (hi8 == 8'hC3) || (hi8 == 8'hC7) || (hi4 == 4'h9) || (hi4 == 4'hD) ||
                     (hi4 == 4'h4 && (lo8 == 8'h0E || lo8 == 8'h07));
  assign illegal_o = branch_o || other_bad;
endmodule

// File: rtl/brslot_target.sv
module brslot_target
  import brslot_pkg::*;
#(
  parameter int AW = 32
) (
  input  br_kind_e      kind_i,
  input  logic [11:0]   disp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic [AW-1:0] exc_pc_i,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] link_o
);
  localparam int D12 = 12;
  localparam int D8  = 8;

  logic [AW-1:0] pc4, off12, off8;

  assign pc4   = pc_i + AW'(4);
  assign off12 = {{(AW-D12-1){disp_i[D12-1]}}, disp_i[D12-1:0], 1'b0};
  assign off8  = {{(AW-D8-1){disp_i[D8-1]}}, disp_i[D8-1:0], 1'b0};
  assign link_o = pc4;

  always_comb begin
    case (kind_i)
      K_BRA, K_BSR:               target_o = pc4 + off12;
      K_BT, K_BF, K_BTS, K_BFS:   target_o = pc4 + off8;
      K_BRAF, K_BSRF:             target_o = pc4 + reg_val_i;
      K_JMP, K_JSR:               target_o = reg_val_i;
      K_RTS:                      target_o = ret_addr_i;
      K_RTE:                      target_o = exc_pc_i;
      default:                    target_o = pc4;
    endcase
  end
endmodule

// File: rtl/brslot_seq.sv
module brslot_seq #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          branch_i,
  input  logic          delayed_i,
  input  logic          taken_i,
  input  logic          call_i,
  input  logic          illegal_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] link_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_addr_o,
  output logic          slot_illegal_o
);
  logic          in_slot_q, pend_q;
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_q      <= 1'b0;
      pend_q         <= 1'b0;
      tgt_q          <= '0;
      redirect_o     <= 1'b0;
      target_o       <= '0;
      link_we_o      <= 1'b0;
      link_addr_o    <= '0;
      slot_illegal_o <= 1'b0;
    end else begin
      redirect_o     <= 1'b0;
      link_we_o      <= 1'b0;
      slot_illegal_o <= 1'b0;
      if (valid_i) begin
        if (in_slot_q) begin
          in_slot_q <= 1'b0;
          pend_q    <= 1'b0;
          if (illegal_i) begin
            slot_illegal_o <= 1'b1;
          end else if (pend_q) begin
            redirect_o <= 1'b1;
            target_o   <= tgt_q;
          end
        end else begin
          if (branch_i && taken_i && !delayed_i) begin
            redirect_o <= 1'b1;
            target_o   <= target_i;
          end
          if (delayed_i) begin
            in_slot_q <= 1'b1;
            pend_q    <= taken_i;
            tgt_q     <= target_i;
          end
          if (call_i) begin
            link_we_o   <= 1'b1;
            link_addr_o <= link_i;
          end
        end
      end
    end
  end

  a_r9_fault_blocks_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_illegal_o |-> !redirect_o);
  a_r9_fault_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_illegal_o |=> !slot_illegal_o);
  a_r4_redirect_after_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_slot_q && pend_q && !illegal_i) |=> (redirect_o && target_o == $past(tgt_q)));
  a_r10_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!redirect_o && !link_we_o && !slot_illegal_o && $stable(in_slot_q)));
  a_r8_call_links: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_slot_q && call_i) |=> (link_we_o && link_addr_o == $past(link_i)));
endmodule

// File: rtl/branch_slot_ctrl.sv
module branch_slot_ctrl
  import brslot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [15:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          t_flag_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic [AW-1:0] exc_pc_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_addr_o,
  output logic          slot_illegal_o
);
  br_kind_e      kind;
  logic          branch, delayed, taken, call, illegal;
  logic [AW-1:0] tgt, link;

  brslot_decode i_dec (
    .instr_i   (instr_i),
    .t_flag_i  (t_flag_i),
    .kind_o    (kind),
    .branch_o  (branch),
    .delayed_o (delayed),
    .taken_o   (taken),
    .call_o    (call),
    .illegal_o (illegal)
  );

  brslot_target #(.AW(AW)) i_tgt (
    .kind_i     (kind),
    .disp_i     (instr_i[11:0]),
    .pc_i       (pc_i),
    .reg_val_i  (reg_val_i),
    .ret_addr_i (ret_addr_i),
    .exc_pc_i   (exc_pc_i),
    .target_o   (tgt),
    .link_o     (link)
  );

  brslot_seq #(.AW(AW)) i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (valid_i),
    .branch_i       (branch),
    .delayed_i      (delayed),
    .taken_i        (taken),
    .call_i         (call),
    .illegal_i      (illegal),
    .target_i       (tgt),
    .link_i         (link),
    .redirect_o     (redirect_o),
    .target_o       (target_o),
    .link_we_o      (link_we_o),
    .link_addr_o    (link_addr_o),
    .slot_illegal_o (slot_illegal_o)
  );
endmodule

// File: tb/test_branch_slot_ctrl.sv
`timescale 1ns/1ps
module test_branch_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic        t_flag_i = 1'b0;
  logic [31:0] reg_val_i = '0;
  logic [31:0] ret_addr_i = '0;
  logic [31:0] exc_pc_i = '0;
  logic        redirect_o, link_we_o, slot_illegal_o;
  logic [31:0] target_o, link_addr_o;

  always #10 clk = ~clk;

  branch_slot_ctrl i_branch_slot_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .t_flag_i(t_flag_i), .reg_val_i(reg_val_i), .ret_addr_i(ret_addr_i), .exc_pc_i(exc_pc_i),
    .redirect_o(redirect_o), .target_o(target_o), .link_we_o(link_we_o),
    .link_addr_o(link_addr_o), .slot_illegal_o(slot_illegal_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // reference model state
  bit m_slot = 0, m_pend = 0;
  logic [31:0] m_tgt = '0;
  bit e_redir = 0, e_lwe = 0, e_ill = 0;
  logic [31:0] e_tgt = '0, e_link = '0;
  string tag_q = "R1";

  function automatic bit bad_in_slot(logic [15:0] w);
    bit r = 0;
    if (w[15:12] == 4'hA || w[15:12] == 4'hB || w[15:12] == 4'h9 || w[15:12] == 4'hD) r = 1;
    if (w[15:8] == 8'h89 || w[15:8] == 8'h8B || w[15:8] == 8'h8D || w[15:8] == 8'h8F) r = 1;
    if (w[15:8] == 8'hC3 || w[15:8] == 8'hC7) r = 1;
    if (w == 16'h000B || w == 16'h002B) r = 1;
    if (w[15:12] == 4'h0 && (w[7:0] == 8'h23 || w[7:0] == 8'h03)) r = 1;
    if (w[15:12] == 4'h4 && (w[7:0] == 8'h2B || w[7:0] == 8'h0B || w[7:0] == 8'h0E || w[7:0] == 8'h07)) r = 1;
    return r;
  endfunction

  task automatic model(bit v, logic [15:0] w, logic [31:0] pc, bit t, logic [31:0] rg,
                       logic [31:0] rt, logic [31:0] ex);
    bit has_slot = 0, go = 0, call = 0;
    int d;
    logic [31:0] dest = '0;
    e_redir = 0; e_lwe = 0; e_ill = 0;
    if (!v) return;
    if (m_slot) begin
      m_slot = 0;
      if (bad_in_slot(w)) e_ill = 1;
      else if (m_pend) begin e_redir = 1; e_tgt = m_tgt; end
      m_pend = 0;
      return;
    end
    if (w[15:12] == 4'hA || w[15:12] == 4'hB) begin
      d = int'(w[11:0]); if (d >= 2048) d -= 4096;
      has_slot = 1; go = 1; call = (w[15:12] == 4'hB);
      dest = pc + 32'(4 + 2 * d);
    end else if (w[15:8] == 8'h89 || w[15:8] == 8'h8B || w[15:8] == 8'h8D || w[15:8] == 8'h8F) begin
      d = int'(w[7:0]); if (d >= 128) d -= 256;
      go = (w[15:8] == 8'h89 || w[15:8] == 8'h8D) ? t : !t;
      has_slot = (w[15:8] == 8'h8D || w[15:8] == 8'h8F);
      dest = pc + 32'(4 + 2 * d);
    end else if (w == 16'h000B) begin has_slot = 1; go = 1; dest = rt;
    end else if (w == 16'h002B) begin has_slot = 1; go = 1; dest = ex;
    end else if (w[15:12] == 4'h0 && (w[7:0] == 8'h23 || w[7:0] == 8'h03)) begin
      has_slot = 1; go = 1; dest = pc + 4 + rg; call = (w[7:0] == 8'h03);
    end else if (w[15:12] == 4'h4 && (w[7:0] == 8'h2B || w[7:0] == 8'h0B)) begin
      has_slot = 1; go = 1; dest = rg; call = (w[7:0] == 8'h0B);
    end
    if (has_slot) begin m_slot = 1; m_pend = go; m_tgt = dest; end
    else if (go) begin e_redir = 1; e_tgt = dest; end
    if (call) begin e_lwe = 1; e_link = pc + 4; end
  endtask

  task automatic compare();
    bit ok;
    ok = (redirect_o == e_redir) && (link_we_o == e_lwe) && (slot_illegal_o == e_ill) &&
         (!e_redir || target_o == e_tgt) && (!e_lwe || link_addr_o == e_link);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got redir=%0d tgt=%h lwe=%0d link=%h ill=%0d, exp redir=%0d tgt=%h lwe=%0d link=%h ill=%0d",
               tag_q, redirect_o, target_o, link_we_o, link_addr_o, slot_illegal_o,
               e_redir, e_tgt, e_lwe, e_link, e_ill);
    end
  endtask

  task automatic step(bit v, logic [15:0] w, logic [31:0] pc, bit t, logic [31:0] rg,
                      logic [31:0] rt, logic [31:0] ex, string tag);
    @(negedge clk);
    compare();
    valid_i = v; instr_i = w; pc_i = pc; t_flag_i = t;
    reg_val_i = rg; ret_addr_i = rt; exc_pc_i = ex;
    model(v, w, pc, t, rg, rt, ex);
    tag_q = tag;
  endtask

  task automatic ins(logic [15:0] w, logic [31:0] pc, string tag);
    step(1, w, pc, 0, 32'h0, 32'h0, 32'h0, tag);
  endtask

  task automatic idle(string tag);
    step(0, 16'h0000, 32'h0, 0, 32'h0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    if (redirect_o || link_we_o || slot_illegal_o || target_o != 0 || link_addr_o != 0) begin
      fails++; $display("FAIL R1: outputs %0d %0d %0d %h %h exp all zero",
                        redirect_o, link_we_o, slot_illegal_o, target_o, link_addr_o);
    end
    checks++;
    rst_ni = 1'b1;
    idle("R1"); idle("R1");
    // R11: ordinary instructions
    ins(16'h0009, 32'h100, "R11"); ins(16'h6103, 32'h102, "R11"); idle("R11");
    // R2: 12-bit branch forward and backward
    ins(16'hA010, 32'h1000, "R2"); ins(16'h0009, 32'h1002, "R2"); idle("R2");
    ins(16'hAFFE, 32'h1000, "R2"); ins(16'h0009, 32'h1002, "R2"); idle("R2");
    ins(16'hA800, 32'h4000, "R2"); ins(16'h0009, 32'h4002, "R2"); idle("R2");
    // R8 + R2: 12-bit call
    ins(16'hB100, 32'h2000, "R8"); ins(16'h0009, 32'h2002, "R8"); idle("R8");
    // R3: slotless conditional
    step(1, 16'h8905, 32'h300, 1, 0, 0, 0, "R3"); idle("R3");
    step(1, 16'h8905, 32'h300, 0, 0, 0, 0, "R3"); idle("R3");
    step(1, 16'h8B80, 32'h300, 0, 0, 0, 0, "R3"); idle("R3");
    step(1, 16'h8B80, 32'h300, 1, 0, 0, 0, "R3"); ins(16'h0009, 32'h302, "R3"); idle("R3");
    // R4: slotted conditional
    step(1, 16'h8D02, 32'h400, 1, 0, 0, 0, "R4"); ins(16'h0009, 32'h402, "R4"); idle("R4");
    step(1, 16'h8FFF, 32'h400, 0, 0, 0, 0, "R4"); ins(16'h0009, 32'h402, "R4"); idle("R4");
    step(1, 16'h8F02, 32'h400, 1, 0, 0, 0, "R4"); ins(16'h0009, 32'h402, "R4"); idle("R4");
    step(1, 16'h8D02, 32'h400, 0, 0, 0, 0, "R4"); ins(16'hA000, 32'h402, "R4"); idle("R4");
    // R5: register-relative branch and call
    step(1, 16'h0323, 32'h500, 0, 32'h40, 0, 0, "R5"); ins(16'h0009, 32'h502, "R5"); idle("R5");
    step(1, 16'h0503, 32'h600, 0, 32'hFFFF_FFF0, 0, 0, "R5"); ins(16'h0009, 32'h602, "R5"); idle("R5");
    // R6: register jumps
    step(1, 16'h432B, 32'h700, 0, 32'h8000_1234, 0, 0, "R6"); ins(16'h0009, 32'h702, "R6"); idle("R6");
    step(1, 16'h420B, 32'h800, 0, 32'h0000_2468, 0, 0, "R6"); ins(16'h0009, 32'h802, "R6"); idle("R6");
    // R7: returns; sources change during the slot
    step(1, 16'h000B, 32'h900, 0, 0, 32'hABC0, 32'h1111, "R7");
    step(1, 16'h0009, 32'h902, 0, 0, 32'h5555, 32'h5555, "R7"); idle("R7");
    step(1, 16'h002B, 32'hA00, 0, 0, 32'h2222, 32'h7770, "R7");
    step(1, 16'h0009, 32'hA02, 0, 0, 32'h5555, 32'h5555, "R7"); idle("R7");
    // R10: stalls inside a slot
    ins(16'hA020, 32'hB00, "R10"); idle("R10"); idle("R10"); idle("R10");
    ins(16'h0009, 32'hB02, "R10"); idle("R10");
    step(0, 16'hA020, 32'hC00, 1, 0, 0, 0, "R10"); step(0, 16'h8901, 32'hC00, 1, 0, 0, 0, "R10"); idle("R10");
    // R9: each fault class in a slot
    begin
      logic [15:0] bad [11] = '{16'hC320, 16'hC701, 16'h9123, 16'hD123, 16'h410E, 16'h4107,
                                16'h8901, 16'h000B, 16'h0323, 16'h432B, 16'hB001};
      foreach (bad[k]) begin
        ins(16'hA010, 32'hD00, "R9"); ins(bad[k], 32'hD02, "R9"); idle("R9"); ins(16'h0009, 32'hD04, "R9");
      end
    end
    // R9: near-miss legal slot instructions still redirect
    ins(16'hA010, 32'hE00, "R9"); ins(16'h4119, 32'hE02, "R9"); idle("R9");
    ins(16'hA010, 32'hE00, "R9"); ins(16'hC420, 32'hE02, "R9"); idle("R9");
    idle("R11");
    @(negedge clk); compare();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule